// File: doc/BRIEF.md
# Bidirectional SPI Engine

This block moves one serial word at a time, as either the clock-generating master or the clock-following slave. A word is 8 or 16 bits long and travels most significant bit first. The serial clock idles low. Data is captured on its rising edge and advanced on its falling edge. Every serial pin is split into a value, an output enable and an input, so the tristate pads sit outside the block.

There are two pin configurations. In the normal configuration, one wire carries data from master to slave and the other carries data back. In the single-wire configuration, the master uses only its MOSI line and the slave uses only its MISO line. That line's driver is switched by a direction bit.

As master, the block can watch slave-select for another master pulling it low. When that happens, it latches a fault and lets go of every pin. Changing the word length or the pin arrangement while a master transfer runs throws the transfer away. A wait input can freeze the master's clock.

Top module: `spi_bidir_engine`

## Requirements
- R1: Master with `cfg_wide`=0: the low byte of `tx_word` leaves on the serial output MSB first in 8 SCK periods, and `rx_word` ends up as 8'h00 followed by the byte received.
- R2: Master with `cfg_wide`=1: all 16 bits of `tx_word` leave MSB first, and the full 16-bit word received is placed in `rx_word`.
- R3: `done` goes high exactly one `clk` cycle after the clock edge that samples the last bit. It stays high until the next transfer begins, which clears it. `rx_word` changes only in the cycle where `done` rises.
- R4: In master mode, toggling `cfg_wide` while `busy` is high ends the transfer at once: `busy` goes low, `sck_o` goes low, `done` does not rise and `rx_word` keeps its value.
- R5: In master mode with `cfg_bidir`=0: `sck_oe`=1, `mosi_oe`=1 and `miso_oe`=0. Received data is taken from `miso_i` on rising SCK, and SCK idles low.
- R6: In master mode with `cfg_bidir`=1: `miso_oe`=0, `mosi_oe` equals `cfg_bidir_oe`, and received data is taken from `mosi_i`.
- R7: In master mode, toggling `cfg_bidir` during a transfer aborts it. Toggling `cfg_bidir_oe` during a transfer also aborts it, but only when `cfg_bidir`=1. With `cfg_bidir`=0, toggling `cfg_bidir_oe` has no effect on a transfer.
- R8: In master mode with `cfg_fault_en`=1, `ss_i` low sets `fault`. A running transfer is aborted, and `sck_oe`, `mosi_oe` and `miso_oe` are all 0 while `fault` is set. `fault` stays set after `ss_i` returns high, and it is cleared only by `fault_clr`.
- R9: In master mode with `cfg_fault_en`=0, `ss_i` is ignored: `fault` stays 0 and transfers complete normally.
- R10: In slave mode (`cfg_master`=0), `ss_i` low selects the block and `ss_i` is always an input. With `cfg_bidir`=0, the slave samples `mosi_i` on rising `sck_i` and drives `miso_o` with `tx_word` MSB first. `miso_oe`=1 only while selected, `sck_oe`=0 and `mosi_oe`=0, and `fault` never sets.
- R11: In slave mode with `cfg_bidir`=1, MISO is the only data line. `miso_i` is sampled, `miso_oe` equals `cfg_bidir_oe` while selected, and `mosi_oe`=0.
- R12: In master mode, `cfg_wait_stop`=1 together with `wait_req`=1 freezes `sck_o` and the transfer, which resumes intact once the wait ends. With `cfg_wait_stop`=0, `wait_req` has no effect.
- R13: `start` is ignored while a transfer is running or while `fault` is set. A running transfer's outgoing word is not reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_wide | input | 1 | 0 = 8-bit words, 1 = 16-bit words |
| cfg_fault_en | input | 1 | Enables slave-select fault watching in master mode |
| cfg_bidir | input | 1 | 0 = two data wires, 1 = single data wire |
| cfg_bidir_oe | input | 1 | Driver enable of the single data wire |
| cfg_wait_stop | input | 1 | Freeze the master clock while waiting |
| wait_req | input | 1 | Wait condition from the system |
| start | input | 1 | Master: begin a transfer (one-cycle pulse) |
| fault_clr | input | 1 | Clears the sticky fault flag |
| tx_word | input | WORD_W | Word to send |
| rx_word | output | WORD_W | Last word received |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Completion flag |
| fault | output | 1 | Sticky mode-fault flag |
| sck_o | output | 1 | Serial clock out |
| sck_oe | output | 1 | Serial clock driver enable |
| sck_i | input | 1 | Serial clock in (slave) |
| ss_i | input | 1 | Slave-select in, active low |
| mosi_o | output | 1 | MOSI value |
| mosi_oe | output | 1 | MOSI driver enable |
| mosi_i | input | 1 | MOSI pad input |
| miso_o | output | 1 | MISO value |
| miso_oe | output | 1 | MISO driver enable |
| miso_i | input | 1 | MISO pad input |

## Verification
The stimulus feeds the unused data wire with the complement of the real data. A design that samples the wrong pin in either pin configuration therefore returns an inverted word instead of a lucky match.

Aborts are provoked partway through a word by flipping the width, the pin configuration, or the direction bit in single-wire mode. A design that misses one of these finishes the transfer and raises an unexpected `done` that the scoreboard rejects. The same direction flip in two-wire mode must not abort, so a design that aborts too eagerly loses an expected word.

A second `start` in mid-transfer must not corrupt the outgoing word. A wait with clock stopping enabled must hold SCK without losing bits. A slave-select low with fault watching enabled must latch a fault that outlives the pin and releases every driver.

// File: rtl/spi_bidir_engine.sv
module spi_bidir_engine #(
  parameter int CLK_DIV = 4,
  parameter int WORD_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_master,
  input  logic              cfg_wide,
  input  logic              cfg_fault_en,
  input  logic              cfg_bidir,
  input  logic              cfg_bidir_oe,
  input  logic              cfg_wait_stop,
  input  logic              wait_req,
  input  logic              start,
  input  logic              fault_clr,
  input  logic [WORD_W-1:0] tx_word,
  output logic [WORD_W-1:0] rx_word,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              sck_i,
  input  logic              ss_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              miso_i
);
  localparam int HALF  = WORD_W / 2;
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [1:0] sck_sy, ss_sy, sdi_sy;
  logic       sck_p, ss_p;
  logic       prev_wide, prev_bidir, prev_oe;
  logic [WORD_W-1:0] sh_tx, sh_rx;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DIV_W-1:0]  div_cnt;
  logic              sck_q, fin;

  logic sel, stall, cfg_moved, fault_hit, m_abort, m_tick, m_go, s_go, s_drop;
  logic rise_ev, fall_ev, din, fin_go, last_bit;
  logic [CNT_W-1:0]  nbits;
  logic [WORD_W-1:0] load;

  assign sel       = !ss_sy[1];
  assign nbits     = cfg_wide ? CNT_W'(WORD_W) : CNT_W'(HALF);
  assign last_bit  = (bit_cnt == nbits - CNT_W'(1));
  assign stall     = cfg_master && cfg_wait_stop && wait_req;
  assign cfg_moved = (cfg_wide != prev_wide) || (cfg_bidir != prev_bidir) ||
                     (cfg_bidir && (cfg_bidir_oe != prev_oe));
  assign fault_hit = cfg_master && cfg_fault_en && !ss_sy[1];
  assign m_abort   = cfg_master && busy && (cfg_moved || fault_hit || fault);
  assign m_tick    = cfg_master && busy && !fin && !stall && (div_cnt == DIV_W'(CLK_DIV - 1));
  assign m_go      = cfg_master && start && !busy && !fault && !fault_hit;
  assign s_go      = !cfg_master && ss_p && !ss_sy[1];
  assign s_drop    = !cfg_master && busy && !sel;
  assign fin_go    = fin && !stall;
  assign din       = cfg_master ? (cfg_bidir ? mosi_i : miso_i) : sdi_sy[1];
  assign rise_ev   = cfg_master ? (m_tick && !sck_q) : (busy && sel && sck_sy[1] && !sck_p);
  assign fall_ev   = cfg_master ? (m_tick && sck_q)  : (busy && sel && !sck_sy[1] && sck_p);
  assign load      = cfg_wide ? tx_word : {tx_word[HALF-1:0], {HALF{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy <= '0;
      ss_sy  <= 2'b11;
      sdi_sy <= '0;
      sck_p  <= 1'b0;
      ss_p   <= 1'b1;
      prev_wide  <= 1'b0;
      prev_bidir <= 1'b0;
      prev_oe    <= 1'b0;
    end else begin
      sck_sy <= {sck_sy[0], sck_i};
      ss_sy  <= {ss_sy[0], ss_i};
      sdi_sy <= {sdi_sy[0], cfg_bidir ? miso_i : mosi_i};
      sck_p  <= sck_sy[1];
      ss_p   <= ss_sy[1];
      prev_wide  <= cfg_wide;
      prev_bidir <= cfg_bidir;
      prev_oe    <= cfg_bidir_oe;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fault <= 1'b0;
    else if (fault_hit) fault <= 1'b1;
    else if (fault_clr) fault <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; fin <= 1'b0; sck_q <= 1'b0;
      div_cnt <= '0; bit_cnt <= '0; sh_tx <= '0; sh_rx <= '0; rx_word <= '0;
    end else if (m_abort || s_drop) begin
      busy <= 1'b0; fin <= 1'b0; sck_q <= 1'b0; div_cnt <= '0;
    end else if (m_go || s_go) begin
      busy <= 1'b1; done <= 1'b0; fin <= 1'b0; sck_q <= 1'b0;
      div_cnt <= '0; bit_cnt <= '0; sh_tx <= load; sh_rx <= '0;
    end else if (fin_go) begin
      busy <= 1'b0; fin <= 1'b0; sck_q <= 1'b0; done <= 1'b1;
      rx_word <= cfg_wide ? sh_rx : {{HALF{1'b0}}, sh_rx[HALF-1:0]};
    end else if (busy) begin
      if (cfg_master && !stall)
        div_cnt <= (div_cnt == DIV_W'(CLK_DIV - 1)) ? '0 : div_cnt + DIV_W'(1);
      if (m_tick) sck_q <= !sck_q;
      if (rise_ev) begin
        sh_rx   <= {sh_rx[WORD_W-2:0], din};
        bit_cnt <= bit_cnt + CNT_W'(1);
        if (last_bit) fin <= 1'b1;
      end
      if (fall_ev) sh_tx <= {sh_tx[WORD_W-2:0], 1'b0};
    end
  end

  assign sck_o   = sck_q;
  assign sck_oe  = cfg_master && !fault;
  assign mosi_o  = sh_tx[WORD_W-1];
  assign miso_o  = sh_tx[WORD_W-1];
  assign mosi_oe = cfg_master && !fault && (!cfg_bidir || cfg_bidir_oe);
  assign miso_oe = !cfg_master && sel && (!cfg_bidir || cfg_bidir_oe);
endmodule

// File: rtl/spi_bidir_engine_sva.sv
module spi_bidir_engine_sva #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_master,
  input logic         cfg_wide,
  input logic         cfg_bidir,
  input logic         cfg_bidir_oe,
  input logic         cfg_fault_en,
  input logic         cfg_wait_stop,
  input logic         wait_req,
  input logic         busy,
  input logic         done,
  input logic         fault,
  input logic [W-1:0] rx_word,
  input logic         sck_o,
  input logic         sck_oe,
  input logic         mosi_oe,
  input logic         miso_oe
);
  a_r3_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  a_r3_rx_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_word != $past(rx_word)) |-> $rose(done));

  a_r4_width_change_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && busy && cfg_wide != $past(cfg_wide)) |=> !busy);

  a_r6_bidir_master_miso_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && cfg_bidir) |-> !miso_oe);

  a_r7_pin_cfg_change_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && busy && cfg_bidir != $past(cfg_bidir)) |=> !busy);

  a_r8_fault_stops_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && fault) |=> !busy);

  a_r10_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master |-> (!sck_oe && !mosi_oe));

  a_r10_slave_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master |=> !$rose(fault));

  a_r12_wait_freezes_sck: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && cfg_wait_stop && wait_req && !cfg_fault_en &&
     cfg_wide == $past(cfg_wide) && cfg_bidir == $past(cfg_bidir) &&
     cfg_bidir_oe == $past(cfg_bidir_oe)) |=> $stable(sck_o));
endmodule

bind spi_bidir_engine spi_bidir_engine_sva #(.W(WORD_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_wide(cfg_wide),
  .cfg_bidir(cfg_bidir), .cfg_bidir_oe(cfg_bidir_oe), .cfg_fault_en(cfg_fault_en),
  .cfg_wait_stop(cfg_wait_stop), .wait_req(wait_req), .busy(busy), .done(done),
  .fault(fault), .rx_word(rx_word), .sck_o(sck_o), .sck_oe(sck_oe),
  .mosi_oe(mosi_oe), .miso_oe(miso_oe)
);

// File: tb/spi_bidir_engine_tb.sv
`timescale 1ns/1ps
module spi_bidir_engine_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_master, cfg_wide, cfg_fault_en, cfg_bidir, cfg_bidir_oe, cfg_wait_stop;
  logic wait_req, start, fault_clr, sck_i, ss_i, mosi_i, miso_i;
  logic [15:0] tx_word, rx_word;
  logic busy, done, fault, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;

  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  spi_bidir_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_wide(cfg_wide),
    .cfg_fault_en(cfg_fault_en), .cfg_bidir(cfg_bidir), .cfg_bidir_oe(cfg_bidir_oe),
    .cfg_wait_stop(cfg_wait_stop), .wait_req(wait_req), .start(start),
    .fault_clr(fault_clr), .tx_word(tx_word), .rx_word(rx_word), .busy(busy),
    .done(done), .fault(fault), .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i),
    .ss_i(ss_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
    .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // mosi_line: 1 puts data on mosi_i and its complement on miso_i
  task automatic drive_line(input logic b, input logic mosi_line);
    if (mosi_line) begin mosi_i = b; miso_i = ~b; end
    else begin miso_i = b; mosi_i = ~b; end
  endtask

  task automatic m_xfer(input logic [15:0] tx, input logic [15:0] peer, input logic bid, input string tag);
    logic [15:0] sh, cap, exp_rx, exp_tx;
    int nb;
    nb     = cfg_wide ? 16 : 8;
    sh     = cfg_wide ? peer : {peer[7:0], 8'h00};
    exp_rx = cfg_wide ? peer : {8'h00, peer[7:0]};
    exp_tx = cfg_wide ? tx : {8'h00, tx[7:0]};
    cap = '0;
    drive_line(sh[15], bid);
    exp_q.push_back(exp_rx);
    tag_q.push_back(tag);
    @(negedge clk); tx_word = tx; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(tag, "busy after start", busy, 1);
    chk("R3", "done cleared at start", done, 0);
    for (int i = 0; i < nb; i++) begin
      @(posedge sck_o);
      cap = {cap[14:0], mosi_o};
      if (i < nb - 1) begin
        @(negedge sck_o);
        sh = sh << 1;
        drive_line(sh[15], bid);
      end else begin
        @(negedge clk);
        chk("R3", "done low in sampling cycle", done, 0);
        @(negedge clk);
        chk("R3", "done one cycle after last sample", done, 1);
      end
    end
    if (!bid) chk(tag, "serial output word", cap & (cfg_wide ? 16'hFFFF : 16'h00FF), exp_tx);
    tick(2);
    chk("R3", "done held after completion", done, 1);
  endtask

  task automatic s_xfer(input logic [15:0] tx, input logic [15:0] peer, input logic bid, input string tag);
    logic [15:0] sh, cap, exp_rx, exp_tx;
    int nb;
    nb     = cfg_wide ? 16 : 8;
    sh     = cfg_wide ? peer : {peer[7:0], 8'h00};
    exp_rx = cfg_wide ? peer : {8'h00, peer[7:0]};
    exp_tx = cfg_wide ? tx : {8'h00, tx[7:0]};
    cap = '0;
    tx_word = tx;
    exp_q.push_back(exp_rx);
    tag_q.push_back(tag);
    @(negedge clk); ss_i = 1'b0;
    drive_line(sh[15], !bid);
    tick(8);
    chk(tag, "miso_oe while selected", miso_oe, bid ? cfg_bidir_oe : 1'b1);
    chk(tag, "mosi_oe in slave", mosi_oe, 0);
    for (int i = 0; i < nb; i++) begin
      cap = {cap[14:0], miso_o};
      sck_i = 1'b1;
      tick(8);
      sck_i = 1'b0;
      sh = sh << 1;
      drive_line(sh[15], !bid);
      tick(8);
    end
    chk(tag, "slave done", done, 1);
    ss_i = 1'b1;
    tick(4);
    chk(tag, "miso_oe released when deselected", miso_oe, 0);
    if (!bid) chk(tag, "slave serial output word", cap & (cfg_wide ? 16'hFFFF : 16'h00FF), exp_tx);
  endtask

  task automatic pulse_start(input logic [15:0] tx);
    @(negedge clk); tx_word = tx; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // scoreboard monitor
  initial begin
    logic seen;
    logic [15:0] e;
    string t;
    seen = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && done && !seen) begin
        if (exp_q.size() == 0) chk("R3", "unexpected done", 1, 0);
        else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(t, "received word", rx_word, e);
        end
      end
      seen = done;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    logic [15:0] saved;
    logic s0, stable;
    cfg_master = 1; cfg_wide = 0; cfg_fault_en = 0; cfg_bidir = 0; cfg_bidir_oe = 0;
    cfg_wait_stop = 0; wait_req = 0; start = 0; fault_clr = 0; sck_i = 0; ss_i = 1;
    mosi_i = 0; miso_i = 0; tx_word = '0;
    tick(5); rst_n = 1'b1; tick(2);

    chk("R3", "reset done", done, 0);
    chk("R3", "reset rx_word", rx_word, 0);
    chk("R8", "reset fault", fault, 0);
    chk("R5", "reset sck idle low", sck_o, 0);
    chk("R13", "reset busy", busy, 0);

    chk("R5", "sck_oe master", sck_oe, 1);
    chk("R5", "mosi_oe master normal", mosi_oe, 1);
    chk("R5", "miso_oe master normal", miso_oe, 0);

    cfg_wide = 0;
    m_xfer(16'h12A5, 16'h3C96, 0, "R1");
    m_xfer(16'hFF01, 16'hAA80, 0, "R1");
    cfg_wide = 1;
    m_xfer(16'hBEEF, 16'h5A3C, 0, "R2");
    m_xfer(16'h8001, 16'h7FFE, 0, "R2");
    m_xfer(16'h0F0F, 16'hC001, 0, "R5");

    cfg_bidir = 1; cfg_bidir_oe = 0; tick(2);
    chk("R6", "mosi_oe bidir oe=0", mosi_oe, 0);
    chk("R6", "miso_oe bidir master", miso_oe, 0);
    m_xfer(16'h0000, 16'hC3A5, 1, "R6");
    cfg_bidir_oe = 1; tick(2);
    chk("R6", "mosi_oe bidir oe=1", mosi_oe, 1);
    chk("R6", "miso_oe bidir master oe=1", miso_oe, 0);
    cfg_bidir_oe = 0; cfg_bidir = 0; tick(2);

    // R4: width change aborts
    cfg_wide = 1;
    saved = rx_word;
    pulse_start(16'h4321);
    tick(20);
    cfg_wide = 0;
    tick(2);
    chk("R4", "busy after width change", busy, 0);
    chk("R4", "sck after width change", sck_o, 0);
    tick(100);
    chk("R4", "no done after abort", done, 0);
    chk("R4", "rx_word kept after abort", rx_word, saved);
    cfg_wide = 1; tick(2);

    // R7: oe toggle without bidir has no effect
    fork
      m_xfer(16'h1357, 16'h2468, 0, "R7");
      begin
        tick(20);
        cfg_bidir_oe = 1;
        tick(3);
        chk("R7", "oe toggle with bidir=0 keeps busy", busy, 1);
      end
    join
    cfg_bidir_oe = 0; tick(2);

    pulse_start(16'h5555);
    tick(20);
    cfg_bidir = 1;
    tick(2);
    chk("R7", "busy after pin config change", busy, 0);
    tick(4);
    pulse_start(16'h6666);
    tick(20);
    cfg_bidir_oe = 1;
    tick(2);
    chk("R7", "busy after oe change in bidir", busy, 0);
    cfg_bidir_oe = 0; cfg_bidir = 0;
    tick(100);
    chk("R7", "no done after aborts", done, 0);

    // R13: start while busy
    fork
      m_xfer(16'hA1B2, 16'hC3D4, 0, "R13");
      begin
        tick(40);
        tx_word = 16'hFFFF; start = 1'b1;
        tick(1);
        start = 1'b0;
      end
    join

    // R12: wait freeze
    fork
      m_xfer(16'h6E21, 16'h9D4B, 0, "R12");
      begin
        tick(30);
        cfg_wait_stop = 1; wait_req = 1;
        tick(1);
        s0 = sck_o; stable = 1'b1;
        for (int k = 0; k < 40; k++) begin
          tick(1);
          if (sck_o !== s0) stable = 1'b0;
        end
        chk("R12", "sck frozen during wait", stable, 1);
        chk("R12", "busy held during wait", busy, 1);
        wait_req = 0;
      end
    join
    cfg_wait_stop = 0; wait_req = 1;
    m_xfer(16'h0C0C, 16'h3003, 0, "R12");
    wait_req = 0;

    // R9: slave-select ignored without fault watching
    cfg_fault_en = 0; ss_i = 0; tick(5);
    chk("R9", "fault with ss low and watch off", fault, 0);
    m_xfer(16'h7E7E, 16'h1818, 0, "R9");
    ss_i = 1; tick(3);

    // R8: mode fault
    cfg_fault_en = 1; tick(3);
    pulse_start(16'h9999);
    tick(20);
    ss_i = 0;
    tick(4);
    chk("R8", "fault set", fault, 1);
    chk("R8", "transfer aborted by fault", busy, 0);
    chk("R8", "sck_oe released", sck_oe, 0);
    chk("R8", "mosi_oe released", mosi_oe, 0);
    chk("R8", "miso_oe released", miso_oe, 0);
    ss_i = 1; tick(5);
    chk("R8", "fault sticky", fault, 1);
    pulse_start(16'h1111);
    tick(2);
    chk("R13", "start ignored under fault", busy, 0);
    fault_clr = 1; tick(1); fault_clr = 0; tick(1);
    chk("R8", "fault cleared", fault, 0);
    chk("R8", "sck_oe restored", sck_oe, 1);
    m_xfer(16'h2BAD, 16'hF00D, 0, "R8");
    tick(50);
    chk("R8", "no done after fault abort", exp_q.size(), 0);

    // R10: slave normal
    cfg_master = 0; tick(4);
    chk("R10", "slave sck_oe", sck_oe, 0);
    chk("R10", "slave miso_oe deselected", miso_oe, 0);
    cfg_wide = 0;
    s_xfer(16'h00C7, 16'h005E, 0, "R10");
    cfg_wide = 1;
    s_xfer(16'hD00D, 16'hB16B, 0, "R10");
    chk("R10", "no fault in slave with ss low", fault, 0);

    // R11: slave single wire
    cfg_bidir = 1; cfg_bidir_oe = 0;
    s_xfer(16'h1234, 16'hE7C1, 1, "R11");
    cfg_bidir_oe = 1;
    @(negedge clk); ss_i = 0; tick(6);
    chk("R11", "miso_oe with oe=1 selected", miso_oe, 1);
    chk("R11", "mosi_oe slave bidir", mosi_oe, 0);
    ss_i = 1; tick(6);
    cfg_bidir = 0; cfg_bidir_oe = 0;

    tick(10);
    chk("R3", "all expected words seen", exp_q.size(), 0);
    summary();
  end
endmodule